// File: doc/BRIEF.md
# UART Bit-Clock Source Selector

This block decides where a UART's receive and transmit bit timing comes from. A single 8-bit select register chooses the receive timing source and the transmit timing source. It also sets oversampled (Nx) or isochronous (1x) operation for each direction, and it chooses what drives the DTR modem-control pin. The block emits one-cycle sample enables in the system clock domain. The receive and transmit shift logic uses these enables as its clock enables.

Timing sources are the internal baud generator strobe, which is already synchronous, and three asynchronous pins: a dedicated receive clock pin, the DSR input and the RI input. Each asynchronous pin is synchronized and reduced to its rising edges. In Nx mode a divider turns every N selected edges into one enable. N comes from an oversampling-rate input. In 1x mode every selected edge is an enable. The receiver can also run from the transmitter's selected edge stream, so a single external pin can time both directions.

Top module: `uart_clk_sel`

## Requirements
- R1: While the internal reset is active, and at the first check after it is released, `rx_en_o` and `tx_en_o` are 0, `cfg_rdata_o` reads 0x00 and `dtr_pin_o` equals `dtr_modem_i`. The internal reset asserts with `rst_ni` and deasserts two clock edges after `rst_ni` rises.
- R2: Bits [1:0] select the receive edge source: 00 = receive clock pin, 01 = DSR pin, 10 = baud strobe, 11 = the transmit edge source.
- R3: Bit 3 selects the transmit edge source: 0 = baud strobe, 1 = RI pin.
- R4: Bit 2 (receive) and bit 4 (transmit) select 1x mode when 1. In 1x mode every selected edge produces an enable pulse.
- R5: `chan_rst_i` does not change the select register. A write in the same cycle still takes effect.
- R6: Bit 7 is reserved. It always reads 0, and writing 1 to it has no effect.
- R7: In Nx mode (mode bit 0), an enable is produced on every Nth selected edge, counted from reset or channel reset. N = `os_rate_i`, and the value 0 means 16.
- R8: An asynchronous pin rise sampled high at clock edge m-2 and low at m-3 yields one selected edge whose enable is visible after edge m. A baud strobe sampled at edge m is visible after edge m. A pin held high yields only one edge.
- R9: Bits [6:5] choose the DTR drive: 00 = `dtr_modem_i`, 01 = `tx_en_o`, 10 = the baud strobe delayed by one register.
- R10: Pin code 11 behaves like 00: `dtr_pin_o` follows `dtr_modem_i`.
- R11: `chan_rst_i` clears both Nx counters and forces both enables to 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| chan_rst_i | input | 1 | Synchronous channel reset (counters only) |
| cfg_we_i | input | 1 | Select register write strobe |
| cfg_wdata_i | input | 8 | Select register write data |
| cfg_rdata_o | output | 8 | Select register read value |
| os_rate_i | input | RATE_W | Oversampling factor N (0 means 16) |
| baud_tick_i | input | 1 | Baud generator strobe, synchronous |
| rx_clk_pin_i | input | 1 | Dedicated receive clock pin, asynchronous |
| dsr_pin_i | input | 1 | DSR pin used as alternate receive clock |
| ri_pin_i | input | 1 | RI pin used as external transmit clock |
| dtr_modem_i | input | 1 | DTR level from normal modem control |
| rx_en_o | output | 1 | Receive sample enable |
| tx_en_o | output | 1 | Transmit bit enable |
| dtr_pin_o | output | 1 | DTR pin drive |

## Verification
Each result has a fixed latency. Enables from the baud strobe appear one edge after the strobe is sampled. Enables from a pin appear three edges after the pin is first sampled high. A register write affects enables from the next edge on, and `dtr_pin_o` follows `dtr_modem_i` with no delay. The bench's reference model keeps a sampled history of every pin and advances one step per rising edge. All outputs are compared at the falling edge, after both the design and the model have settled. Inputs change only after that comparison.

// File: rtl/uart_clk_sel_pkg.sv
package uart_clk_sel_pkg;

  typedef enum logic [1:0] {
    RXS_PIN  = 2'b00,
    RXS_DSR  = 2'b01,
    RXS_BAUD = 2'b10,
    RXS_TXCK = 2'b11
  } rx_src_e;

  typedef enum logic [1:0] {
    PIN_MODEM  = 2'b00,
    PIN_TXBIT  = 2'b01,
    PIN_BAUD   = 2'b10,
    PIN_RSVD   = 2'b11
  } pin_mode_e;

  typedef struct packed {
    logic      rsvd;
    pin_mode_e pin_mode;
    logic      tx_1x;
    logic      tx_src;
    logic      rx_1x;
    rx_src_e   rx_src;
  } sel_cfg_t;

  localparam int unsigned CFG_W = $bits(sel_cfg_t);
  localparam logic [CFG_W-1:0] CFG_WMASK = 8'h7F;

  localparam int unsigned LANE_RXPIN = 0;
  localparam int unsigned LANE_DSR   = 1;
  localparam int unsigned LANE_RI    = 2;
  localparam int unsigned NUM_LANES  = 3;

endpackage

// File: rtl/ucs_rst_sync.sv
module ucs_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/ucs_pin_sync.sv
module ucs_pin_sync #(
  parameter int unsigned LANES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] pin_i,
  output logic [LANES-1:0] rise_o
);
  logic [LANES-1:0] meta_q, sync_q, prev_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic meta_d, sync_d, prev_d;

    always_comb begin
      meta_d = pin_i[g];
      sync_d = meta_q[g];
      prev_d = sync_q[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
        prev_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= meta_d;
        sync_q[g] <= sync_d;
        prev_q[g] <= prev_d;
      end
    end

    assign rise_o[g] = sync_q[g] & ~prev_q[g];

    // R8: a held level must not produce a second edge
    p_edge_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/ucs_rate_div.sv
module ucs_rate_div #(
  parameter int unsigned RATE_W   = 5,
  parameter int unsigned DEF_RATE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              one_x_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              en_o
);
  localparam logic [RATE_W-1:0] DEF_LAST = RATE_W'(DEF_RATE - 1);

  logic [RATE_W-1:0] cnt_q, cnt_d, last_cnt;
  logic              en_q, en_d;

  always_comb begin
    last_cnt = (rate_i == '0) ? DEF_LAST : (rate_i - RATE_W'(1));
  end

  always_comb begin
    cnt_d = cnt_q;
    en_d  = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (one_x_i) begin
        en_d = 1'b1;
      end else if (cnt_q >= last_cnt) begin
        en_d  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + RATE_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
    end
  end

  assign en_o = en_q;

  p_en_after_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> ($past(tick_i) && !$past(clr_i)));

  p_every_edge_1x_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && one_x_i && !clr_i) |=> en_q);

  p_clear_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !en_q);
endmodule

// File: rtl/ucs_cfg_reg.sv
module ucs_cfg_reg
  import uart_clk_sel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output sel_cfg_t         cfg_o
);
  logic [CFG_W-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) cfg_d = wdata_i & CFG_WMASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = sel_cfg_t'(cfg_q);
endmodule

// File: rtl/uart_clk_sel.sv
module uart_clk_sel
  import uart_clk_sel_pkg::*;
#(
  parameter int unsigned RATE_W   = 5,
  parameter int unsigned DEF_RATE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chan_rst_i,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic [RATE_W-1:0] os_rate_i,
  input  logic              baud_tick_i,
  input  logic              rx_clk_pin_i,
  input  logic              dsr_pin_i,
  input  logic              ri_pin_i,
  input  logic              dtr_modem_i,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              dtr_pin_o
);
  localparam int unsigned DIRS = 2;
  localparam int unsigned D_RX = 0;
  localparam int unsigned D_TX = 1;

  logic                 rst_n;
  logic [NUM_LANES-1:0] pins, rises;
  sel_cfg_t             cfg;
  logic                 tx_tick, rx_tick;
  logic [DIRS-1:0]      dir_tick, dir_1x, dir_en;
  logic                 baud_q, baud_d;

  ucs_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  always_comb begin
    pins             = '0;
    pins[LANE_RXPIN] = rx_clk_pin_i;
    pins[LANE_DSR]   = dsr_pin_i;
    pins[LANE_RI]    = ri_pin_i;
  end

  ucs_pin_sync #(.LANES(NUM_LANES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .pin_i  (pins),
    .rise_o (rises)
  );

  ucs_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  assign cfg_rdata_o = cfg;

  always_comb begin
    tx_tick = cfg.tx_src ? rises[LANE_RI] : baud_tick_i;
    unique case (cfg.rx_src)
      RXS_PIN:  rx_tick = rises[LANE_RXPIN];
      RXS_DSR:  rx_tick = rises[LANE_DSR];
      RXS_BAUD: rx_tick = baud_tick_i;
      default:  rx_tick = tx_tick;
    endcase
    dir_tick = '0;
    dir_1x   = '0;
    dir_tick[D_RX] = rx_tick;
    dir_tick[D_TX] = tx_tick;
    dir_1x[D_RX]   = cfg.rx_1x;
    dir_1x[D_TX]   = cfg.tx_1x;
  end

  for (genvar d = 0; d < DIRS; d++) begin : g_dir
    ucs_rate_div #(.RATE_W(RATE_W), .DEF_RATE(DEF_RATE)) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_n),
      .clr_i   (chan_rst_i),
      .tick_i  (dir_tick[d]),
      .one_x_i (dir_1x[d]),
      .rate_i  (os_rate_i),
      .en_o    (dir_en[d])
    );
  end

  assign rx_en_o = dir_en[D_RX];
  assign tx_en_o = dir_en[D_TX];

  always_comb baud_d = baud_tick_i;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) baud_q <= 1'b0;
    else        baud_q <= baud_d;
  end

  always_comb begin
    case (cfg.pin_mode)
      PIN_TXBIT: dtr_pin_o = dir_en[D_TX];
      PIN_BAUD:  dtr_pin_o = baud_q;
      default:   dtr_pin_o = dtr_modem_i;
    endcase
  end

  p_cfg_hold_chanrst_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (chan_rst_i && !cfg_we_i) |=> $stable(cfg_rdata_o));

  p_rsvd_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    cfg_we_i |=> !cfg_rdata_o[7]);

  p_rx_borrows_tx_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cfg.rx_src == RXS_TXCK && cfg.rx_1x && cfg.tx_1x && !chan_rst_i && !cfg_we_i)
      |=> (rx_en_o == tx_en_o));
endmodule

// File: tb/tb_uart_clk_sel.sv
module tb_uart_clk_sel;
  localparam int RATE_W = 5;

  logic clk, rst_n, chan_rst, cfg_we;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic [RATE_W-1:0] os_rate;
  logic baud_tick, rx_pin, dsr_pin, ri_pin, dtr_modem;
  logic rx_en, tx_en, dtr_pin;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  uart_clk_sel #(.RATE_W(RATE_W), .DEF_RATE(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .chan_rst_i(chan_rst),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .os_rate_i(os_rate), .baud_tick_i(baud_tick),
    .rx_clk_pin_i(rx_pin), .dsr_pin_i(dsr_pin), .ri_pin_i(ri_pin),
    .dtr_modem_i(dtr_modem), .rx_en_o(rx_en), .tx_en_o(tx_en), .dtr_pin_o(dtr_pin)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference
  bit hq_rx[$], hq_dsr[$], hq_ri[$];
  int rel;
  int m_cfg, m_rxc, m_txc;
  bit m_rx_en, m_tx_en, m_baud_q;

  function automatic void clear_model();
    hq_rx = '{0,0,0}; hq_dsr = '{0,0,0}; hq_ri = '{0,0,0};
    m_cfg = 0; m_rxc = 0; m_txc = 0;
    m_rx_en = 0; m_tx_en = 0; m_baud_q = 0;
  endfunction

  function automatic bit rose(ref bit q[$]);
    return q[1] && !q[2];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 0;
      clear_model();
    end else if (rel < 2) begin
      rel++;
    end else begin
      bit e_rx, e_dsr, e_ri, ttx, trx;
      int n;
      e_rx = rose(hq_rx); e_dsr = rose(hq_dsr); e_ri = rose(hq_ri);
      hq_rx.push_front(rx_pin);   hq_rx.pop_back();
      hq_dsr.push_front(dsr_pin); hq_dsr.pop_back();
      hq_ri.push_front(ri_pin);   hq_ri.pop_back();
      ttx = m_cfg[3] ? e_ri : baud_tick;
      case (m_cfg & 3)
        0: trx = e_rx;
        1: trx = e_dsr;
        2: trx = baud_tick;
        default: trx = ttx;
      endcase
      n = (os_rate == 0) ? 16 : int'(os_rate);
      m_rx_en = 0; m_tx_en = 0;
      if (chan_rst) begin
        m_rxc = 0; m_txc = 0;
      end else begin
        if (trx) begin
          if (m_cfg[2]) m_rx_en = 1;
          else if (m_rxc + 1 >= n) begin m_rx_en = 1; m_rxc = 0; end
          else m_rxc++;
        end
        if (ttx) begin
          if (m_cfg[4]) m_tx_en = 1;
          else if (m_txc + 1 >= n) begin m_tx_en = 1; m_txc = 0; end
          else m_txc++;
        end
      end
      m_baud_q = baud_tick;
      if (cfg_we) m_cfg = cfg_wdata & 8'h7F;
    end
  end

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic bit exp_dtr();
    case ((m_cfg >> 5) & 3)
      1: return m_tx_en;
      2: return m_baud_q;
      default: return dtr_modem;
    endcase
  endfunction

  task automatic compare(string tag);
    chk(tag, "rx_en", rx_en, m_rx_en);
    chk(tag, "tx_en", tx_en, m_tx_en);
    chk(tag, "dtr", dtr_pin, exp_dtr());
    chk(tag, "rdata", cfg_rdata, m_cfg);
  endtask

  task automatic step(string tag, bit we, logic [7:0] wd, bit crst);
    @(negedge clk);
    compare(tag);
    rx_pin    = 1'($urandom_range(0, 1));
    dsr_pin   = 1'($urandom_range(0, 1));
    ri_pin    = 1'($urandom_range(0, 1));
    baud_tick = 1'($urandom_range(0, 1));
    dtr_modem = 1'($urandom_range(0, 1));
    cfg_we = we; cfg_wdata = wd; chan_rst = crst;
  endtask

  task automatic run(string tag, int cycles, bit rand_crst);
    for (int i = 0; i < cycles; i++)
      step(tag, 0, 8'h00, rand_crst && ($urandom_range(0, 7) == 0));
  endtask

  task automatic wr(string tag, logic [7:0] v);
    step(tag, 1, v, 0);
  endtask

  initial begin
    rst_n = 0; chan_rst = 0; cfg_we = 0; cfg_wdata = 0; os_rate = 0;
    baud_tick = 0; rx_pin = 0; dsr_pin = 0; ri_pin = 0; dtr_modem = 1;
    repeat (3) begin
      @(negedge clk);
      chk("R1", "reset rx_en", rx_en, 0);
      chk("R1", "reset tx_en", tx_en, 0);
      chk("R1", "reset rdata", cfg_rdata, 0);
      chk("R1", "reset dtr", dtr_pin, dtr_modem);
      dtr_modem = ~dtr_modem;
    end
    rst_n = 1;
    run("R1", 6, 0);

    wr("R6", 8'h80); run("R6", 2, 0);
    chk("R6", "reserved write", cfg_rdata, 8'h00);
    wr("R6", 8'hFF); run("R6", 2, 0);
    chk("R6", "all ones write", cfg_rdata, 8'h7F);

    for (int s = 0; s < 4; s++) begin
      wr("R2", 8'(8'h14 | s)); run("R2", 150, 0);
    end
    wr("R3", 8'h10); run("R3", 120, 0);
    wr("R3", 8'h18); run("R3", 120, 0);
    wr("R8", 8'h04); run("R8", 150, 0);
    wr("R4", 8'h16); run("R4", 120, 0);

    os_rate = 0; wr("R7", 8'h02); run("R7", 300, 0);
    os_rate = 3; run("R7", 200, 0);
    os_rate = 5; wr("R7", 8'h0A); run("R7", 250, 0);
    os_rate = 1; run("R7", 60, 0);

    os_rate = 2;
    wr("R9", 8'h30); run("R9", 120, 0);
    wr("R9", 8'h40); run("R9", 120, 0);
    wr("R9", 8'h00); run("R9", 80, 0);
    wr("R10", 8'h60); run("R10", 100, 0);

    os_rate = 4; wr("R11", 8'h02); run("R11", 300, 1);
    wr("R5", 8'h2A); run("R5", 2, 0);
    step("R5", 0, 8'h00, 1); run("R5", 3, 0);
    chk("R5", "hold after chan_rst", cfg_rdata, 8'h2A);
    step("R5", 1, 8'h35, 1); run("R5", 3, 0);
    chk("R5", "write beats chan_rst", cfg_rdata, 8'h35);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule